// File: doc/BRIEF.md
# RTC Serial Register-Access Slave

This block is the serial front end of a real-time-clock register file. A host addresses sixteen byte-wide registers over a four-wire serial bus. The chip select is active high and the clock idles low. Each transaction opens with a command byte. Its upper nibble names a register and two of its lower bits pick a single or burst read or write. The data bytes that follow move between the bus and the registers. A burst walks through consecutive addresses, so the whole time set can be moved in one transaction.

Registers 0 to 6 (seconds, minutes, hours, weekday, day of month, month, year) and 7 to 13 live in the timekeeping core. The block reaches them through a simple port: a combinational read address with returned data, and a registered one-cycle write strobe. Two control registers are held inside the block. Control 1 sits at address 14, and its bit 5 selects 24-hour mode. Control 2 sits at address 15 and carries the sticky oscillator-stop and voltage-low flags, which are set by plain event inputs. The serial pins are sampled in the system clock domain through synchronizers, so the serial clock must be slow against the system clock: each half period needs at least six system clocks.

Top module: `rtcspi_slave`

## Requirements
- R1: The command byte is decoded as follows. Bits [7:4] are the start address. Bit 3 set means single access and clear means burst. Bit 2 set means read and clear means write. Bits [1:0] are ignored. So 0x8 in the low nibble is a single write, 0xC a single read, 0x0 a burst write and 0x4 a burst read.
- R2: Bytes travel MSB first. MOSI is sampled on the falling edge of the serial clock. MISO changes after a rising edge and holds until the next falling edge. The chip select is active high.
- R3: In a single write, the first data byte is written to the commanded address and every later byte of that transaction is discarded. Addresses 0 to 13 are written through regWrEn, regWrAddr and regWrData.
- R4: In a burst write, data byte k goes to address (start+k) mod 16, so address 15 is followed by address 0.
- R5: In a single read, the first data byte returns the commanded register. Every later byte returns 0x00.
- R6: In a burst read, data byte k returns register (start+k) mod 16, with the same wrap from 15 to 0.
- R7: Reading address 0 always returns bit 7 as 0, whatever the core supplies.
- R8: Control 1 (address 14) and control 2 (address 15) are held in the block and are never forwarded to the core write port. Bit 5 of control 1 drives hour24.
- R9: Control 2 bit 4 is the oscillator-stop flag and bit 6 is the voltage-low flag. Each flag is set in every cycle its event input is high. A write can only clear a flag: the new flag is the old flag AND the written bit, so writing 0x00 clears both. An event that is high wins over a clearing write. All other bits of control 2 store the written value.
- R10: Deasserting chip select drops any partial byte without a write and resets the bit count. The next assertion starts again with a command byte.
- R11: MISO is 0 while chip select is low, during the command byte, and throughout write transactions.
- R12: After reset regWrEn is 0, MISO is 0, control 1 is 0x00 (hour24 low) and control 2 is 0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| spiSclk | input | 1 | Serial clock from host, idles low |
| spiCs | input | 1 | Chip select, active high |
| spiMosi | input | 1 | Serial data from host |
| spiMiso | output | 1 | Serial data to host |
| regRdAddr | output | 4 | Read address toward the timekeeping core |
| regRdData | input | 8 | Combinational read data from the core |
| regWrEn | output | 1 | One-cycle write strobe toward the core |
| regWrAddr | output | 4 | Write address toward the core |
| regWrData | output | 8 | Write data toward the core |
| oscStopEvt | input | 1 | Oscillator-stop event, sets control 2 bit 4 |
| voltLowEvt | input | 1 | Voltage-low event, sets control 2 bit 6 |
| hour24 | output | 1 | 24-hour mode select (control 1 bit 5) |

## Verification
Two situations are hard to reach from the pins. The first is a chip select that drops part-way through a byte. The bench makes it by shifting only four bits, once inside a data byte and once inside a command byte. It then issues a normal read, which would misalign if the bit count survived. The second is a flag event that lands in the same cycle as a clearing write to control 2. The bench holds the oscillator-stop event high for the whole of a transaction that writes 0x00, so the collision cycle is certain to occur. It then reads back a set flag alongside a cleared voltage-low flag.

// File: rtl/rtcspi_pkg.sv
`timescale 1ns/1ps
package rtcspi_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int CNT_W = $clog2(DATA_W);
  localparam int CMD_READ_BIT = 2;
  localparam int CMD_SINGLE_BIT = 3;
  localparam int SEC_MSB = DATA_W - 1;
  localparam int H24_BIT = 5;
  localparam int OSC_BIT = 4;
  localparam int VLOW_BIT = 6;
  localparam logic [ADDR_W-1:0] SEC_ADDR = '0;
  localparam logic [ADDR_W-1:0] CTL1_ADDR = ADDR_W'(2**ADDR_W - 2);
  localparam logic [ADDR_W-1:0] CTL2_ADDR = ADDR_W'(2**ADDR_W - 1);
  localparam logic [DATA_W-1:0] FLAG_MASK = DATA_W'((1 << OSC_BIT) | (1 << VLOW_BIT));
  localparam logic [DATA_W-1:0] CTL2_RST = DATA_W'(1 << OSC_BIT);

  typedef struct packed {
    logic shiftRx;   // capture MOSI bit
    logic shiftTx;   // advance MISO shifter
    logic loadTx;    // load read byte into shifter
    logic clearTx;   // zero the shifter
    logic wrByte;    // commit received byte to addr
  } dpStrobeT;
endpackage

// File: rtl/rtcspi_sync.sv
`timescale 1ns/1ps
module rtcspi_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic spiSclk,
  input  logic spiCs,
  input  logic spiMosi,
  output logic csOn,
  output logic sclkRise,
  output logic sclkFall,
  output logic mosiBit
);
  logic [SYNC_STAGES-1:0] csS;
  logic [SYNC_STAGES-1:0] mosiS;
  logic [SYNC_STAGES:0] sclkS;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csS <= '0;
      mosiS <= '0;
      sclkS <= '0;
    end else begin
      csS <= {csS[SYNC_STAGES-2:0], spiCs};
      mosiS <= {mosiS[SYNC_STAGES-2:0], spiMosi};
      sclkS <= {sclkS[SYNC_STAGES-1:0], spiSclk};
    end
  end

  assign csOn = csS[SYNC_STAGES-1];
  assign mosiBit = mosiS[SYNC_STAGES-1];
  assign sclkRise = sclkS[SYNC_STAGES-1] & ~sclkS[SYNC_STAGES];
  assign sclkFall = ~sclkS[SYNC_STAGES-1] & sclkS[SYNC_STAGES];
endmodule

// File: rtl/rtcspi_ctrl.sv
`timescale 1ns/1ps
module rtcspi_ctrl
  import rtcspi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csOn,
  input  logic              sclkRise,
  input  logic              sclkFall,
  input  logic [DATA_W-1:0] rxByte,
  output dpStrobeT          st,
  output logic [ADDR_W-1:0] addr
);
  logic [CNT_W-1:0] bitCnt;
  logic cmdSeen, dataSeen, isRead, isSingle, pendLoad, pendClr;
  logic byteDone;
  logic unusedCmdBits;

  assign unusedCmdBits = &{1'b0, rxByte[1:0]};
  assign byteDone = csOn & sclkFall & (bitCnt == CNT_W'(DATA_W - 1));

  always_comb begin
    st.shiftRx = csOn & sclkFall;
    st.shiftTx = csOn & sclkRise & (bitCnt != '0);
    st.loadTx = pendLoad;
    st.clearTx = pendClr;
    st.wrByte = byteDone & cmdSeen & ~isRead & (~isSingle | ~dataSeen);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
      cmdSeen <= 1'b0;
      dataSeen <= 1'b0;
      isRead <= 1'b0;
      isSingle <= 1'b0;
      pendLoad <= 1'b0;
      pendClr <= 1'b0;
      addr <= '0;
    end else if (!csOn) begin
      bitCnt <= '0;
      cmdSeen <= 1'b0;
      dataSeen <= 1'b0;
      pendLoad <= 1'b0;
      pendClr <= 1'b0;
    end else begin
      pendLoad <= 1'b0;
      pendClr <= 1'b0;
      if (sclkFall) begin
        bitCnt <= (bitCnt == CNT_W'(DATA_W - 1)) ? '0 : bitCnt + 1'b1;
      end
      if (byteDone) begin
        if (!cmdSeen) begin
          cmdSeen <= 1'b1;
          addr <= rxByte[DATA_W-1 -: ADDR_W];
          isRead <= rxByte[CMD_READ_BIT];
          isSingle <= rxByte[CMD_SINGLE_BIT];
          pendLoad <= rxByte[CMD_READ_BIT];
        end else begin
          dataSeen <= 1'b1;
          if (!isSingle) begin
            addr <= addr + 1'b1;
            pendLoad <= isRead;
          end else begin
            pendClr <= 1'b1;
          end
        end
      end
    end
  end

  // R4
  burst_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && cmdSeen && !isSingle) |=> addr == ADDR_W'($past(addr) + 1'b1));

  // R10
  fresh_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csOn) |-> (bitCnt == '0 && !cmdSeen));
endmodule

// File: rtl/rtcspi_dp.sv
`timescale 1ns/1ps
module rtcspi_dp
  import rtcspi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          st,
  input  logic              csOn,
  input  logic              mosiBit,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] rxByte,
  output logic              miso,
  output logic [ADDR_W-1:0] regRdAddr,
  input  logic [DATA_W-1:0] regRdData,
  output logic              regWrEn,
  output logic [ADDR_W-1:0] regWrAddr,
  output logic [DATA_W-1:0] regWrData,
  input  logic              oscStopEvt,
  input  logic              voltLowEvt,
  output logic              hour24
);
  logic [DATA_W-1:0] rxShift, txShift, rdByte;
  logic [DATA_W-1:0] ctl1Q, ctl2Q, ctl2Next, ctl2Base, evtVec;
  logic ctl2Wr;

  assign rxByte = {rxShift[DATA_W-2:0], mosiBit};
  assign miso = txShift[DATA_W-1];
  assign regRdAddr = addr;
  assign hour24 = ctl1Q[H24_BIT];

  always_comb begin
    if (addr == CTL1_ADDR) rdByte = ctl1Q;
    else if (addr == CTL2_ADDR) rdByte = ctl2Q;
    else begin
      rdByte = regRdData;
      if (addr == SEC_ADDR) rdByte[SEC_MSB] = 1'b0;
    end
  end

  always_comb begin
    evtVec = '0;
    evtVec[OSC_BIT] = oscStopEvt;
    evtVec[VLOW_BIT] = voltLowEvt;
    ctl2Wr = st.wrByte && (addr == CTL2_ADDR);
    ctl2Base = ctl2Wr ? ((rxByte & ~FLAG_MASK) | (rxByte & ctl2Q & FLAG_MASK)) : ctl2Q;
    ctl2Next = ctl2Base | evtVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      ctl1Q <= '0;
      ctl2Q <= CTL2_RST;
      regWrEn <= 1'b0;
      regWrAddr <= '0;
      regWrData <= '0;
    end else begin
      if (st.shiftRx) rxShift <= rxByte;
      if (!csOn || st.clearTx) txShift <= '0;
      else if (st.loadTx) txShift <= rdByte;
      else if (st.shiftTx) txShift <= {txShift[DATA_W-2:0], 1'b0};
      if (st.wrByte && addr == CTL1_ADDR) ctl1Q <= rxByte;
      ctl2Q <= ctl2Next;
      regWrEn <= st.wrByte && (addr < CTL1_ADDR);
      if (st.wrByte) begin
        regWrAddr <= addr;
        regWrData <= rxByte;
      end
    end
  end

  // R11
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csOn |=> !miso);

  // R7
  sec_msb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.loadTx && addr == SEC_ADDR) |=> !miso);

  // R9
  osc_flag_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl2Q[OSC_BIT]) |-> $past(oscStopEvt));

  // R9
  vlow_flag_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl2Q[VLOW_BIT]) |-> $past(voltLowEvt));

  // R8
  ctl_local_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> regWrAddr < CTL1_ADDR);
endmodule

// File: rtl/rtcspi_slave.sv
`timescale 1ns/1ps
module rtcspi_slave
  import rtcspi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiSclk,
  input  logic              spiCs,
  input  logic              spiMosi,
  output logic              spiMiso,
  output logic [ADDR_W-1:0] regRdAddr,
  input  logic [DATA_W-1:0] regRdData,
  output logic              regWrEn,
  output logic [ADDR_W-1:0] regWrAddr,
  output logic [DATA_W-1:0] regWrData,
  input  logic              oscStopEvt,
  input  logic              voltLowEvt,
  output logic              hour24
);
  logic csOn, sclkRise, sclkFall, mosiBit;
  logic [DATA_W-1:0] rxByte;
  logic [ADDR_W-1:0] addr;
  dpStrobeT st;

  rtcspi_sync #(.SYNC_STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .spiSclk(spiSclk), .spiCs(spiCs), .spiMosi(spiMosi),
    .csOn(csOn), .sclkRise(sclkRise), .sclkFall(sclkFall), .mosiBit(mosiBit)
  );

  rtcspi_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .csOn(csOn), .sclkRise(sclkRise), .sclkFall(sclkFall),
    .rxByte(rxByte), .st(st), .addr(addr)
  );

  rtcspi_dp uDp (
    .clk(clk), .rstN(rstN), .st(st), .csOn(csOn), .mosiBit(mosiBit), .addr(addr),
    .rxByte(rxByte), .miso(spiMiso), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .oscStopEvt(oscStopEvt), .voltLowEvt(voltLowEvt), .hour24(hour24)
  );
endmodule

// File: tb/tb_rtcspi_slave.sv
`timescale 1ns/1ps
module tb_rtcspi_slave;
  localparam int H = 8;
  localparam int NV = 11;

  typedef struct packed {
    logic [7:0] cmd;
    logic [7:0] d0, d1, d2;
    logic [7:0] e0, e1, e2;
    logic [7:0] req;
  } vecT;

  localparam vecT VECS [NV] = '{
    '{8'h0C, 8'h00, 8'h00, 8'h00, 8'h25, 8'h00, 8'h00, 8'd7},  // R7 R5 single read, masked MSB
    '{8'hF4, 8'h00, 8'h00, 8'h00, 8'h10, 8'h25, 8'h11, 8'd12}, // R12 R6 reset ctl2, wrap
    '{8'h00, 8'h45, 8'h59, 8'h23, 8'h00, 8'h00, 8'h00, 8'd11}, // R11 R4 burst write
    '{8'h04, 8'h00, 8'h00, 8'h00, 8'h45, 8'h59, 8'h23, 8'd6},  // R6 R2 burst read back
    '{8'h38, 8'h05, 8'h77, 8'h66, 8'h00, 8'h00, 8'h00, 8'd3},  // R3 single write
    '{8'h34, 8'h00, 8'h00, 8'h00, 8'h05, 8'h14, 8'h15, 8'd3},  // R3 later bytes discarded
    '{8'h3F, 8'h00, 8'h00, 8'h00, 8'h05, 8'h00, 8'h00, 8'd1},  // R1 low bits ignored
    '{8'hE0, 8'h20, 8'h00, 8'h99, 8'h00, 8'h00, 8'h00, 8'd4},  // R4 wrap through ctl regs
    '{8'hE4, 8'h00, 8'h00, 8'h00, 8'h20, 8'h00, 8'h19, 8'd8},  // R8 R9 ctl1, cleared ctl2
    '{8'h5B, 8'h12, 8'h34, 8'h56, 8'h00, 8'h00, 8'h00, 8'd1},  // R1 single write, bits 1:0 set
    '{8'h5C, 8'h00, 8'h00, 8'h00, 8'h12, 8'h00, 8'h00, 8'd5}   // R5 trailing zeros
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiSclk = 1'b0, spiCs = 1'b0, spiMosi = 1'b0;
  logic spiMiso, regWrEn, hour24;
  logic [3:0] regRdAddr, regWrAddr;
  logic [7:0] regRdData, regWrData;
  logic oscStopEvt = 1'b0, voltLowEvt = 1'b0;
  logic [7:0] coreMem [0:13];
  int total = 0, bad = 0, wrPulses = 0, fwdBad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtcspi_slave dut (
    .clk(clk), .rstN(rstN), .spiSclk(spiSclk), .spiCs(spiCs), .spiMosi(spiMosi),
    .spiMiso(spiMiso), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .oscStopEvt(oscStopEvt), .voltLowEvt(voltLowEvt), .hour24(hour24)
  );

  // behavioural timekeeping core
  assign regRdData = (regRdAddr < 4'd14) ? coreMem[regRdAddr] : 8'hEE;
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 14; i++) coreMem[i] <= 8'h10 + 8'(i);
      coreMem[0] <= 8'hA5;
    end else if (regWrEn) begin
      wrPulses <= wrPulses + 1;
      if (regWrAddr < 4'd14) coreMem[regWrAddr] <= regWrData;
      else fwdBad <= fwdBad + 1;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic spiBits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      spiMosi = tx[i];
      spiSclk = 1'b1;
      tick(H);
      rx[i] = spiMiso;
      spiSclk = 1'b0;
      tick(H);
    end
  endtask

  task automatic csOpen();
    spiCs = 1'b1;
    tick(2 * H);
  endtask

  task automatic csClose();
    spiCs = 1'b0;
    tick(2 * H);
  endtask

  task automatic xfer(input logic [7:0] cmd, input logic [7:0] d0, d1, d2,
                      output logic [7:0] r0, r1, r2);
    logic [7:0] rc;
    csOpen();
    spiBits(cmd, 8, rc);
    chk(rc == 8'h00, "R11 cmd-byte miso", rc, 0);
    spiBits(d0, 8, r0);
    spiBits(d1, 8, r1);
    spiBits(d2, 8, r2);
    csClose();
  endtask

  task automatic rd1(input logic [7:0] cmd, output logic [7:0] r0);
    logic [7:0] x1, x2;
    xfer(cmd, 8'h00, 8'h00, 8'h00, r0, x1, x2);
  endtask

  task automatic wr1(input logic [7:0] cmd, input logic [7:0] d);
    logic [7:0] x0, x1, x2;
    xfer(cmd, d, 8'h00, 8'h00, x0, x1, x2);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [7:0] r0, r1, r2, junk;
    tick(5);
    rstN = 1'b1;
    tick(5);
    // R12 reset state
    chk(spiMiso == 1'b0, "R12 miso", spiMiso, 0);
    chk(regWrEn == 1'b0, "R12 regWrEn", regWrEn, 0);
    chk(hour24 == 1'b0, "R12 hour24", hour24, 0);

    // vector walk: R1 R2 R3 R4 R5 R6 R7 R8 R9 R11 R12
    for (int v = 0; v < NV; v++) begin
      xfer(VECS[v].cmd, VECS[v].d0, VECS[v].d1, VECS[v].d2, r0, r1, r2);
      chk(r0 == VECS[v].e0, $sformatf("R%0d vec%0d byte0", VECS[v].req, v), r0, VECS[v].e0);
      chk(r1 == VECS[v].e1, $sformatf("R%0d vec%0d byte1", VECS[v].req, v), r1, VECS[v].e1);
      chk(r2 == VECS[v].e2, $sformatf("R%0d vec%0d byte2", VECS[v].req, v), r2, VECS[v].e2);
    end
    // R8 hour24 follows ctl1 bit 5
    chk(hour24 == 1'b1, "R8 hour24 set", hour24, 1);

    // R10 abort inside a data byte
    csOpen();
    spiBits(8'hE8, 8, junk);
    spiBits(8'hF0, 4, junk);
    csClose();
    rd1(8'hEC, r0);
    chk(r0 == 8'h20, "R10 partial data byte dropped", r0, 8'h20);
    // R10 abort inside a command byte
    csOpen();
    spiBits(8'hE0, 4, junk);
    csClose();
    rd1(8'hEC, r0);
    chk(r0 == 8'h20, "R10 partial command dropped", r0, 8'h20);

    // R9 flag set, masked write, collision
    voltLowEvt = 1'b1;
    tick(3);
    voltLowEvt = 1'b0;
    tick(2);
    rd1(8'hFC, r0);
    chk(r0 == 8'h40, "R9 voltage flag set", r0, 8'h40);
    wr1(8'hF8, 8'h53);
    rd1(8'hFC, r0);
    chk(r0 == 8'h43, "R9 write cannot set flag", r0, 8'h43);
    oscStopEvt = 1'b1;
    wr1(8'hF8, 8'h00);
    oscStopEvt = 1'b0;
    tick(2);
    rd1(8'hFC, r0);
    chk(r0 == 8'h10, "R9 event beats clear", r0, 8'h10);

    // R8 hour24 cleared by ctl1 write
    wr1(8'hE8, 8'h00);
    chk(hour24 == 1'b0, "R8 hour24 clear", hour24, 0);

    // R3 R10 write-strobe count, R8 no forwarding of ctl addresses
    chk(wrPulses == 6, "R3 core write count", wrPulses, 6);
    chk(fwdBad == 0, "R8 ctl write forwarded", fwdBad, 0);
    finishRun();
  end
endmodule